// File: doc/BRIEF.md
# Bidirectional Bus Port with Stored/Live Select

This block sits between two 9-bit bidirectional buses, A and B, and a pair of FIFOs. One FIFO carries traffic from A to B, the other from B to A. A shared pair of controls sets which bus, if either, the block drives: an active-high drive-off input and a direction input. Each direction also has its own select. That select decides whether the driven bus carries live data passing straight through from the opposite bus, or the read output of the FIFO that feeds that bus.

Every bus value and every drive enable that leaves the block comes straight from a flop. The select decode and the direction decode both resolve before a clock edge. This means a change of select or direction can never produce a decode glitch on a driven bus. The two bus inputs are wired unconditionally to the FIFO write-data ports, so either FIFO can be loaded while the other bus is being driven. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bbp_port`

## Requirements
- R1: While reset is held, and until the first clock edge after the synchronized release, both drive enables are 0 and both bus outputs are 0.
- R2: When `drive_off` is 1, the next clock edge clears both `a_drive` and `b_drive`, so both buses are left as inputs.
- R3: When `drive_off` is 0 and `to_b` is 1, the next clock edge sets `b_drive` to 1 and `a_drive` to 0.
- R4: When `drive_off` is 0 and `to_b` is 0, the next clock edge sets `a_drive` to 1 and `b_drive` to 0.
- R5: When `b_from_fifo` is 0, `b_out` takes the value of `a_in` at the next clock edge (live pass-through).
- R6: When `b_from_fifo` is 1, `b_out` takes the value of `fa_rdata` at the next clock edge (stored data).
- R7: When `a_from_fifo` is 0, `a_out` takes the value of `b_in` at the next clock edge (live pass-through).
- R8: When `a_from_fifo` is 1, `a_out` takes the value of `fb_rdata` at the next clock edge (stored data).
- R9: `fa_wdata` always equals `a_in` and `fb_wdata` always equals `b_in`, with no dependence on the selects, direction or drive-off input.
- R10: A change of a select, direction or drive-off input between clock edges leaves `a_out`, `b_out`, `a_drive` and `b_drive` unchanged until the next rising edge.
- R11: `a_drive` and `b_drive` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_off | input | 1 | 1 = drive neither bus |
| to_b | input | 1 | Direction: 1 = drive bus B, 0 = drive bus A |
| b_from_fifo | input | 1 | Source for bus B: 0 = live bus A, 1 = FIFO A read data |
| a_from_fifo | input | 1 | Source for bus A: 0 = live bus B, 1 = FIFO B read data |
| a_in | input | 9 | Value sensed on bus A |
| a_out | output | 9 | Value to drive on bus A |
| a_drive | output | 1 | Tri-state enable for bus A |
| b_in | input | 9 | Value sensed on bus B |
| b_out | output | 9 | Value to drive on bus B |
| b_drive | output | 1 | Tri-state enable for bus B |
| fa_wdata | output | 9 | Write data to FIFO A |
| fa_rdata | input | 9 | Read data from FIFO A |
| fb_wdata | output | 9 | Write data to FIFO B |
| fb_rdata | input | 9 | Read data from FIFO B |

## Verification
The drive enables and both bus outputs are due one rising edge after their inputs are applied. The bench therefore sets the stimulus on a falling edge and samples on the following falling edge. The FIFO write-data ports are combinational, so they are sampled 1 ns after the bus inputs change, with no edge in between. For R10 the bench changes controls in the middle of a cycle. It samples once before the next rising edge, where the old values must still hold, and once after that edge, where the new ones must appear. After reset release the bench waits out the two synchronizer stages plus one further edge before it checks any vector.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_mode_e;
endpackage

// File: rtl/bbp_rst_sync.sv
module bbp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/bbp_drive_ctrl.sv
module bbp_drive_ctrl
  import bbp_pkg::*;
(
  input  logic clk,
  input  logic rst_q,
  input  logic drive_off,
  input  logic to_b,
  output logic a_drive,
  output logic b_drive
);
  drive_mode_e mode_d;
  logic        a_drive_d, b_drive_d;

  always_comb begin
    if (drive_off) mode_d = DRV_NONE;
    else if (to_b) mode_d = DRV_B;
    else           mode_d = DRV_A;
    a_drive_d = (mode_d == DRV_A);
    b_drive_d = (mode_d == DRV_B);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_drive <= 1'b0;
      b_drive <= 1'b0;
    end else begin
      a_drive <= a_drive_d;
      b_drive <= b_drive_d;
    end
  end

  assert_one_side_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !(a_drive && b_drive));
  assert_off_R2: assert property (@(posedge clk) disable iff (!rst_q)
    drive_off |=> (!a_drive && !b_drive));
  assert_drive_b_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (!drive_off && to_b) |=> (b_drive && !a_drive));
  assert_drive_a_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (!drive_off && !to_b) |=> (a_drive && !b_drive));
endmodule

// File: rtl/bbp_lane.sv
module bbp_lane #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic         use_fifo,
  input  logic [W-1:0] live_d,
  input  logic [W-1:0] fifo_d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb q_d = use_fifo ? fifo_d : live_d;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) q <= '0;
    else        q <= q_d;
  end

  assert_stored_R6_R8: assert property (@(posedge clk) disable iff (!rst_q)
    use_fifo |=> (q == $past(fifo_d)));
  assert_live_R5_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !use_fifo |=> (q == $past(live_d)));
endmodule

// File: rtl/bbp_port.sv
module bbp_port #(
  parameter int W          = 9,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drive_off,
  input  logic         to_b,
  input  logic         b_from_fifo,
  input  logic         a_from_fifo,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] fa_wdata,
  input  logic [W-1:0] fa_rdata,
  output logic [W-1:0] fb_wdata,
  input  logic [W-1:0] fb_rdata
);
  logic rst_q;

  bbp_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  bbp_drive_ctrl u_ctrl (
    .clk(clk), .rst_q(rst_q), .drive_off(drive_off), .to_b(to_b),
    .a_drive(a_drive), .b_drive(b_drive)
  );

  // Lane toward bus B: live from A, stored from FIFO A
  bbp_lane #(.W(W)) u_lane_b (
    .clk(clk), .rst_q(rst_q), .use_fifo(b_from_fifo),
    .live_d(a_in), .fifo_d(fa_rdata), .q(b_out)
  );

  // Lane toward bus A: live from B, stored from FIFO B
  bbp_lane #(.W(W)) u_lane_a (
    .clk(clk), .rst_q(rst_q), .use_fifo(a_from_fifo),
    .live_d(b_in), .fifo_d(fb_rdata), .q(a_out)
  );

  // R9: write ports always see the sensed bus values
  assign fa_wdata = a_in;
  assign fb_wdata = b_in;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst_n)
    (!a_drive && !b_drive));
endmodule

// File: tb/bbp_port_test.sv
module bbp_port_test;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic drive_off, to_b, b_from_fifo, a_from_fifo;
  logic [W-1:0] a_in, b_in, fa_rdata, fb_rdata;
  logic [W-1:0] a_out, b_out, fa_wdata, fb_wdata;
  logic a_drive, b_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bbp_port uut (
    .clk(clk), .rst_n(rst_n), .drive_off(drive_off), .to_b(to_b),
    .b_from_fifo(b_from_fifo), .a_from_fifo(a_from_fifo),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .fa_wdata(fa_wdata), .fa_rdata(fa_rdata),
    .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
  );

  // {drive_off, to_b, b_from_fifo, a_from_fifo, exp_a_drive, exp_b_drive}
  localparam logic [5:0] VEC [16] = '{
    6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
    6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
    6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    rst_n = 1'b0; drive_off = 1'b0; to_b = 1'b1;
    b_from_fifo = 1'b0; a_from_fifo = 1'b0;
    a_in = 9'h1A5; b_in = 9'h0C3; fa_rdata = 9'h111; fb_rdata = 9'h1EE;
    repeat (3) @(negedge clk);
    // R1: reset holds enables and data at zero despite active controls
    chk(!a_drive && !b_drive, "R1 drive", {a_drive, b_drive}, 0);
    chk(a_out == 0 && b_out == 0, "R1 data", {a_out, b_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_drive && !b_drive, "R1 sync stage", {a_drive, b_drive}, 0);
    repeat (3) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      logic [5:0] v;
      logic [W-1:0] ea, eb;
      v = VEC[i];
      drive_off = v[5]; to_b = v[4]; b_from_fifo = v[3]; a_from_fifo = v[2];
      a_in = W'(9'h013 + i * 37); b_in = W'(9'h1F0 - i * 29);
      fa_rdata = W'(9'h0AA ^ (i * 11)); fb_rdata = W'(9'h155 ^ (i * 7));
      #1;
      chk(fa_wdata == a_in && fb_wdata == b_in, "R9 write-through",
          {fa_wdata, fb_wdata}, {a_in, b_in});
      eb = v[3] ? fa_rdata : a_in;
      ea = v[2] ? fb_rdata : b_in;
      @(negedge clk);
      if (v[5])      chk(!a_drive && !b_drive, "R2 off", {a_drive, b_drive}, 0);
      else if (v[4]) chk(b_drive && !a_drive, "R3 drive B", {a_drive, b_drive}, 1);
      else           chk(a_drive && !b_drive, "R4 drive A", {a_drive, b_drive}, 2);
      chk(!(a_drive && b_drive), "R11 exclusive", {a_drive, b_drive}, {v[1], v[0]});
      if (v[3]) chk(b_out == eb, "R6 B stored", b_out, eb);
      else      chk(b_out == eb, "R5 B live", b_out, eb);
      if (v[2]) chk(a_out == ea, "R8 A stored", a_out, ea);
      else      chk(a_out == ea, "R7 A live", a_out, ea);
    end

    // R10: mid-cycle control change must not reach outputs before the edge
    drive_off = 1'b0; to_b = 1'b0; b_from_fifo = 1'b0; a_from_fifo = 1'b0;
    a_in = 9'h0F0; b_in = 9'h10F; fa_rdata = 9'h033; fb_rdata = 9'h1CC;
    @(negedge clk);
    chk(a_drive && a_out == 9'h10F && b_out == 9'h0F0, "R10 setup", a_out, 9'h10F);
    #2;
    to_b = 1'b1; b_from_fifo = 1'b1; a_from_fifo = 1'b1;
    #2;
    chk(a_drive && !b_drive, "R10 enables held", {a_drive, b_drive}, 2);
    chk(a_out == 9'h10F && b_out == 9'h0F0, "R10 data held", {a_out, b_out}, {9'h10F, 9'h0F0});
    @(negedge clk);
    chk(b_drive && !a_drive, "R10 enables after edge", {a_drive, b_drive}, 1);
    chk(a_out == 9'h1CC && b_out == 9'h033, "R10 data after edge",
        {a_out, b_out}, {9'h1CC, 9'h033});

    // R9 while the opposite bus is being driven, selects toggling
    b_in = 9'h1AB; a_in = 9'h054; a_from_fifo = 1'b0;
    #1;
    chk(fb_wdata == 9'h1AB && fa_wdata == 9'h054, "R9 during drive",
        {fa_wdata, fb_wdata}, {9'h054, 9'h1AB});

    // R1: asynchronous re-entry into reset clears outputs at once
    rst_n = 1'b0;
    #1;
    chk(!a_drive && !b_drive && a_out == 0 && b_out == 0, "R1 async clear",
        {a_drive, b_drive, a_out, b_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule